// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block connects a two-channel serial audio stream to parallel processing logic. On the receive side it watches an external bit clock, frame clock and data line. All three are brought onto the master clock through synchronizers. A 16-bit word is collected for each channel and delivered as a left/right pair with a one-cycle strobe. The input bit clock may run at any rate that gives at least 16 falling edges per channel half-frame, as long as each of its phases lasts at least two master clocks.

On the transmit side the block divides the master clock (384 times the sample rate) by eight. This gives its own bit clock at 48 times the sample rate and a frame clock at the sample rate. It has nothing to do with the input bit clock. Each frame holds two 24-bit slots, left first. Every slot carries one 16-bit word, most significant bit first, aligned so that the word's last bit ends at the frame-clock edge. The eight bits in front of the word repeat its sign bit. The two parallel words to send are sampled once, when a new frame starts.

Top module: `audio_serial_port`

## Requirements
- R1: Input bits are taken on each falling edge of `bck_in`, MSB first. The word for a channel is the last 16 bits taken before `lrc_in` changes level. When more than 16 falling edges occur in a half-frame, the earliest surplus bits are discarded.
- R2: `lrc_in` high marks the left channel and low marks the right. A high-to-low change ends the left word. A low-to-high change ends the right word, loads `rx_left` and `rx_right`, and raises `rx_valid` for exactly one clock. The received words change at no other time.
- R3: A low-to-high change of `lrc_in` only produces a pair if a left word was ended since the last pair or since reset. The first rising `lrc_in` after reset, with no left word before it, raises no `rx_valid`.
- R4: When a change of `lrc_in` and a falling edge of `bck_in` reach the synchronized logic in the same clock, the bit taken on that edge is the last bit of the word that is ending.
- R5: `bck_out` has a period of 8 master clocks, high for 4 and low for 4.
- R6: `lrc_out` is high for 24 `bck_out` periods (left slot) and then low for 24 periods (right slot), for 48 periods per frame.
- R7: `lrc_out` and `sdata_out` change only on the master clock edge where `bck_out` falls.
- R8: Each output slot carries 8 copies of the word's bit 15, followed by bits 15 down to 0. The last bit is the one in front of the next `lrc_out` change.
- R9: `tx_left` and `tx_right` are sampled on the clock edge where `lrc_out` rises, and that frame sends the sampled values. Changes to them at any other point in the frame have no effect on that frame.
- R10: While `rst` is high, `bck_out`, `lrc_out`, `sdata_out`, `rx_valid`, `rx_left` and `rx_right` are all 0. After release, `bck_out` first rises on the 4th clock edge, and `lrc_out` first rises, with `bck_out` falling, on the 8th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 384 times the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| bck_in | input | 1 | Incoming serial bit clock, asynchronous to `clk` |
| lrc_in | input | 1 | Incoming frame clock, high for left |
| sdata_in | input | 1 | Incoming serial data |
| tx_left | input | 16 | Left word to transmit |
| tx_right | input | 16 | Right word to transmit |
| bck_out | output | 1 | Generated bit clock, `clk` divided by 8 |
| lrc_out | output | 1 | Generated frame clock, high during the left slot |
| sdata_out | output | 1 | Outgoing serial data |
| rx_left | output | 16 | Last received left word |
| rx_right | output | 16 | Last received right word |
| rx_valid | output | 1 | One-clock strobe when a new pair is loaded |

## Verification
In the receiver, a frame-clock change and a bit-clock falling edge can both arrive in one clock. In that case the word capture has to include the bit being shifted in on that same cycle. The bench alternates between frames that change `lrc_in` on a rising `bck_in` and frames that change it on the same instant as the last falling edge. It judges the two against the same expected words, with half-frames of 16 to 32 bits. On the transmit side, a new frame start and the parallel words being sampled fall on the same edge. The bench changes the words twice in the middle of each frame and requires every frame to carry exactly the values present at its own start.

// File: rtl/asp_pkg.sv
package asp_pkg;

  // Frame clock level for each channel, shared by both directions.
  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;

endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (STAGES == 1) begin : g_single
    logic [WIDTH-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else     r <= d;
    end
    assign q = r;
  end else begin : g_chain
    logic [STAGES*WIDTH-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[(STAGES-1)*WIDTH-1:0], d};
    end
    assign q = chain[STAGES*WIDTH-1 -: WIDTH];
  end

endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bck_in,
  input  logic              lrc_in,
  input  logic              sdata_in,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);

  logic [2:0] raw, syn;
  logic       bck_s, lrc_s, sd_s;

  assign raw = {bck_in, lrc_in, sdata_in};

  // All three lines share one synchronizer so their relative timing holds.
  asp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (syn)
  );

  assign bck_s = syn[2];
  assign lrc_s = syn[1];
  assign sd_s  = syn[0];

  logic              bck_d, lrc_d, armed;
  logic              bit_fall, lrc_edge;
  logic [WORD_W-1:0] shreg, left_hold, word_now;

  assign bit_fall = bck_d & ~bck_s;
  assign lrc_edge = lrc_d ^ lrc_s;
  // A bit taken on the same cycle as a channel change still ends the old word.
  assign word_now = bit_fall ? {shreg[WORD_W-2:0], sd_s} : shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      bck_d     <= 1'b0;
      lrc_d     <= 1'b0;
      armed     <= 1'b0;
      shreg     <= '0;
      left_hold <= '0;
      rx_left   <= '0;
      rx_right  <= '0;
      rx_valid  <= 1'b0;
    end else begin
      bck_d    <= bck_s;
      lrc_d    <= lrc_s;
      rx_valid <= 1'b0;
      if (bit_fall) shreg <= {shreg[WORD_W-2:0], sd_s};
      if (lrc_edge) begin
        if (lrc_s == CH_RIGHT) begin
          left_hold <= word_now;
          armed     <= 1'b1;
        end else begin
          if (armed) begin
            rx_left  <= left_hold;
            rx_right <= word_now;
            rx_valid <= 1'b1;
          end
          armed <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SLOT_W  = 24,
  parameter int CLK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              bck_out,
  output logic              lrc_out,
  output logic              sdata_out
);

  localparam int FRAME = 2 * SLOT_W;
  localparam int PH_W  = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(FRAME);
  localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(CLK_DIV / 2 - 1);
  localparam logic [PH_W-1:0]  PH_FALL  = PH_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME - 1);
  localparam logic [BIT_W-1:0] SLOT_B   = BIT_W'(SLOT_W);

  logic [PH_W-1:0]   ph;
  logic [BIT_W-1:0]  bitn, bit_nxt, slot_pos;
  logic [WORD_W-1:0] hold_l, hold_r, cur_word;
  logic              in_left, nxt_data;

  // Next serial position and the bit it carries (right aligned, sign padded).
  always_comb begin
    bit_nxt  = (bitn == BIT_LAST) ? '0 : bitn + BIT_W'(1);
    in_left  = bit_nxt < SLOT_B;
    slot_pos = in_left ? bit_nxt : bit_nxt - SLOT_B;
    if (bit_nxt == '0)  cur_word = tx_left;
    else if (in_left)   cur_word = hold_l;
    else                cur_word = hold_r;
    nxt_data = cur_word[WORD_W-1];
    for (int i = 0; i < WORD_W; i++) begin
      if (int'(slot_pos) == SLOT_W - 1 - i) nxt_data = cur_word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      bitn      <= BIT_LAST;
      bck_out   <= 1'b0;
      lrc_out   <= CH_RIGHT;
      sdata_out <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
    end else begin
      ph <= (ph == PH_FALL) ? '0 : ph + PH_W'(1);
      if (ph == PH_RISE) bck_out <= 1'b1;
      if (ph == PH_FALL) begin
        bck_out   <= 1'b0;
        bitn      <= bit_nxt;
        lrc_out   <= in_left ? CH_LEFT : CH_RIGHT;
        sdata_out <= nxt_data;
        if (bit_nxt == '0) begin
          hold_l <= tx_left;
          hold_r <= tx_right;
        end
      end
    end
  end

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int WORD_W      = 16,
  parameter int SLOT_W      = 24,
  parameter int CLK_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bck_in,
  input  logic              lrc_in,
  input  logic              sdata_in,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic              bck_out,
  output logic              lrc_out,
  output logic              sdata_out,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);

  asp_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .bck_in   (bck_in),
    .lrc_in   (lrc_in),
    .sdata_in (sdata_in),
    .rx_left  (rx_left),
    .rx_right (rx_right),
    .rx_valid (rx_valid)
  );

  asp_tx #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .CLK_DIV(CLK_DIV)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .tx_left   (tx_left),
    .tx_right  (tx_right),
    .bck_out   (bck_out),
    .lrc_out   (lrc_out),
    .sdata_out (sdata_out)
  );

endmodule

// File: rtl/asp_checker.sv
module asp_checker #(
  parameter int WORD_W  = 16,
  parameter int SLOT_W  = 24,
  parameter int CLK_DIV = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bck_out,
  input logic              lrc_out,
  input logic              sdata_out,
  input logic              rx_valid,
  input logic [WORD_W-1:0] rx_left,
  input logic [WORD_W-1:0] rx_right
);

  localparam int HALF  = CLK_DIV / 2;
  localparam int RUN_W = $clog2(CLK_DIV) + 1;
  localparam int CNT_W = $clog2(SLOT_W + 1) + 1;

  logic             bck_d, lrc_d, bck_seen, lrc_seen;
  logic [RUN_W-1:0] run;
  logic [CNT_W-1:0] falls;

  always_ff @(posedge clk) begin
    if (rst) begin
      bck_d    <= 1'b0;
      lrc_d    <= 1'b0;
      bck_seen <= 1'b0;
      lrc_seen <= 1'b0;
      run      <= '0;
      falls    <= '0;
    end else begin
      bck_d <= bck_out;
      lrc_d <= lrc_out;
      if (bck_out != bck_d) begin
        run      <= '0;
        bck_seen <= 1'b1;
      end else if (run != '1) begin
        run <= run + RUN_W'(1);
      end
      if (lrc_out != lrc_d) begin
        falls    <= CNT_W'(1);
        lrc_seen <= 1'b1;
      end else if (bck_d && !bck_out) begin
        falls <= falls + CNT_W'(1);
      end
    end
  end

  a_r5_bck_half: assert property (@(posedge clk) disable iff (rst)
    (bck_seen && bck_out != bck_d) |-> run == RUN_W'(HALF - 1));

  a_r6_slot_len: assert property (@(posedge clk) disable iff (rst)
    (lrc_seen && lrc_out != lrc_d) |-> falls == CNT_W'(SLOT_W));

  a_r7_lrc_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrc_out) |-> $fell(bck_out));

  a_r7_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata_out) |-> $fell(bck_out));

  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r2_words_hold: assert property (@(posedge clk) disable iff (rst)
    (!$stable(rx_left) || !$stable(rx_right)) |-> rx_valid);

endmodule

bind audio_serial_port asp_checker #(
  .WORD_W  (WORD_W),
  .SLOT_W  (SLOT_W),
  .CLK_DIV (CLK_DIV)
) u_asp_checker (
  .clk       (clk),
  .rst       (rst),
  .bck_out   (bck_out),
  .lrc_out   (lrc_out),
  .sdata_out (sdata_out),
  .rx_valid  (rx_valid),
  .rx_left   (rx_left),
  .rx_right  (rx_right)
);

// File: tb/audio_serial_port_bench.sv
module audio_serial_port_bench;

  localparam int DIV   = 8;
  localparam int HB    = 4;   // master clocks per input bit-clock phase
  localparam int NF    = 40;  // received frames
  localparam int TXMIN = 14;  // transmitted frames to judge

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bck_in = 1'b0, lrc_in = 1'b0, sdata_in = 1'b0;
  logic [15:0] tx_left, tx_right;
  logic        bck_out, lrc_out, sdata_out, rx_valid;
  logic [15:0] rx_left, rx_right;

  always #10 clk = ~clk;

  audio_serial_port u_audio_serial_port (
    .clk(clk), .rst(rst), .bck_in(bck_in), .lrc_in(lrc_in), .sdata_in(sdata_in),
    .tx_left(tx_left), .tx_right(tx_right), .bck_out(bck_out), .lrc_out(lrc_out),
    .sdata_out(sdata_out), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  int checks = 0, errors = 0;
  logic [15:0] exp_l [0:63];
  logic [15:0] exp_r [0:63];
  string       exp_tag [0:63];
  int          n_got = 0;
  logic [15:0] txe_l [0:63];
  logic [15:0] txe_r [0:63];
  int          tx_fr = 0, mon_fr = 0;

  function automatic logic [15:0] lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [23:0] sx(input logic [15:0] w);
    return {{8{w[15]}}, w};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One channel half-frame of n bits; lrc changes with the first rising edge,
  // or, when endflip is set, together with the last falling edge.
  task automatic drive_half(input logic [15:0] w, input int n, input logic lvl,
                            input bit endflip, input logic [15:0] junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdata_in = (i < n - 16) ? junk[i % 16] : w[15 - (i - (n - 16))];
      if (i == 0) lrc_in = lvl;
      bck_in = 1'b1;
      repeat (HB) @(negedge clk);
      bck_in = 1'b0;
      if (endflip && i == n - 1) lrc_in = ~lvl;
      repeat (HB - 1) @(negedge clk);
    end
  endtask

  // Receive monitor: R1 R2 R4 pairs in order.
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        if (n_got < NF) begin
          check(rx_left == exp_l[n_got], exp_tag[n_got], "left word", 48'(rx_left), 48'(exp_l[n_got]));
          check(rx_right == exp_r[n_got], exp_tag[n_got], "right word", 48'(rx_right), 48'(exp_r[n_got]));
        end else begin
          check(1'b0, "R2", "extra pair", 48'(n_got), 48'(NF));
        end
        n_got++;
      end
    end
  end

  // Transmit word driver: words change at frame start and twice mid-frame (R9).
  initial begin
    logic [15:0] ts;
    logic dl;
    int tc;
    ts = 16'hACE1; dl = 1'b0; tc = 0;
    tx_left = 16'h8001; tx_right = 16'h7FFE;
    forever begin
      @(negedge clk);
      if (lrc_out && !dl) begin
        if (tx_fr < 64) begin
          txe_l[tx_fr] = tx_left;
          txe_r[tx_fr] = tx_right;
        end
        tx_fr++;
        ts = lfsr(ts);
        tx_left = ts; tx_right = ~ts ^ 16'h00FF;
        tc = 0;
      end else begin
        tc++;
      end
      if (tc == 100) begin
        ts = lfsr(ts); tx_left = ts; ts = lfsr(ts); tx_right = ts;
      end
      if (tc == 250) begin
        if (tx_fr == 1)      begin tx_left = 16'h8000; tx_right = 16'h7FFF; end
        else if (tx_fr == 2) begin tx_left = 16'hFFFF; tx_right = 16'h0000; end
        else begin ts = lfsr(ts); tx_left = ts ^ 16'h5A5A; end
      end
      dl = lrc_out;
    end
  end

  // Transmit monitor: samples on rising bck_out.
  initial begin
    logic pb, pl, pd, last_rl, have_rise, in_frame;
    logic [47:0] db, lb;
    int cyc, pos, bad5, bad7;
    pb = 0; pl = 0; pd = 0; last_rl = 0; have_rise = 0; in_frame = 0;
    db = '0; lb = '0; cyc = 0; pos = 0; bad5 = 0; bad7 = 0;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      cyc++;
      if ((lrc_out != pl || sdata_out != pd) && !(pb && !bck_out)) bad7++;
      if (pb && !bck_out && have_rise && cyc != HB) bad5++;
      if (!pb && bck_out) begin
        if (have_rise && cyc != DIV) bad5++;
        cyc = 0;
        have_rise = 1;
        if (lrc_out && !last_rl) begin pos = 0; in_frame = 1; end
        last_rl = lrc_out;
        if (in_frame) begin
          db[47 - pos] = sdata_out;
          lb[47 - pos] = lrc_out;
          if (pos == 47) begin
            check(bad5 == 0, "R5", "bit clock phase errors", 48'(bad5), 48'd0);
            check(bad7 == 0, "R7", "changes off falling edge", 48'(bad7), 48'd0);
            check(lb == 48'hFFFFFF_000000, "R6", "frame clock pattern", lb, 48'hFFFFFF_000000);
            check(db[47:24] == sx(txe_l[mon_fr]), "R8", "left slot bits", 48'(db[47:24]), 48'(sx(txe_l[mon_fr])));
            check(db[23:0] == sx(txe_r[mon_fr]), "R9", "right slot bits", 48'(db[23:0]), 48'(sx(txe_r[mon_fr])));
            bad5 = 0; bad7 = 0;
            mon_fr++;
            in_frame = 0;
          end else begin
            pos++;
          end
        end
      end
      pb = bck_out; pl = lrc_out; pd = sdata_out;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R2: actual=%0d expected=%0d", n_got, NF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // Main sequence
  initial begin
    int lens [0:4];
    logic [15:0] s, wl, wr;
    bit mb;
    lens[0] = 16; lens[1] = 17; lens[2] = 20; lens[3] = 24; lens[4] = 32;
    s = 16'h1D2B;
    repeat (5) @(negedge clk);
    // R10 reset state
    check({bck_out, lrc_out, sdata_out, rx_valid} == 4'b0, "R10", "serial outputs in reset",
          48'({bck_out, lrc_out, sdata_out, rx_valid}), 48'd0);
    check(rx_left == 16'h0 && rx_right == 16'h0, "R10", "words in reset",
          48'({rx_left, rx_right}), 48'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(bck_out == 1'b0, "R10", "bck_out after 3 edges", 48'(bck_out), 48'd0);
    @(negedge clk);
    check(bck_out == 1'b1, "R10", "bck_out after 4 edges", 48'(bck_out), 48'd1);
    repeat (3) @(negedge clk);
    check(lrc_out == 1'b0, "R10", "lrc_out after 7 edges", 48'(lrc_out), 48'd0);
    @(negedge clk);
    check(lrc_out == 1'b1 && bck_out == 1'b0, "R10", "frame start after 8 edges",
          48'({lrc_out, bck_out}), 48'b10);

    for (int f = 0; f < NF; f++) begin
      case (f)
        0: begin wl = 16'h8000; wr = 16'h7FFF; end
        1: begin wl = 16'h0000; wr = 16'hFFFF; end
        2: begin wl = 16'h0001; wr = 16'h8001; end
        default: begin s = lfsr(s); wl = s; s = lfsr(s); wr = s; end
      endcase
      mb = (f % 2) == 1;
      exp_l[f] = wl; exp_r[f] = wr;
      exp_tag[f] = mb ? "R4" : ((lens[f % 5] > 16) ? "R1" : "R2");
      drive_half(wl, lens[f % 5], 1'b1, mb, ~s);
      if (f == 0) check(n_got == 0, "R3", "no pair on first rising frame clock", 48'(n_got), 48'd0);
      drive_half(wr, lens[(f + 2) % 5], 1'b0, mb, s);
    end
    drive_half(16'h0, 16, 1'b1, 1'b0, 16'h0);
    repeat (20) @(negedge clk);
    check(n_got == NF, "R2", "pair count", 48'(n_got), 48'(NF));
    while (mon_fr < TXMIN) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule